// File: doc/BRIEF.md
# SPI Status Flag Register

This block is the status register of a serial peripheral interface. It holds three flags: byte complete, write collision and mode fault. The serial transfer engine raises each one with a single-cycle event pulse. Software reads the flags through a byte-wide status view. Each flag clears only by a two-step handshake. First, a status read must see the flag set; that read arms the flag. Later, a specific register access clears it. The byte-complete and write-collision flags clear on an access to the data register. The mode-fault flag clears on a write to the control register.

If a new event for a flag arrives before its clearing access, the flag stays set. The arming is also withdrawn, so software must read the status again before the flag can be cleared. The block also watches for receive overrun: a byte completes while the byte-complete flag from the previous byte is still set. Every pin is a plain control or status strobe. No stream is involved, so there is no back-pressure.

Top module: `spi_stat_flags`

## Requirements
- R1: After reset, and whenever rst_n is low, all flags are zero, stat_rdata reads 0x00 and ovr_o is low.
- R2: A pulse on ev_done sets the byte-complete flag at bit 7 of stat_rdata from the next cycle. This holds in master and slave operation alike.
- R3: A pulse on ev_coll sets the write-collision flag at bit 6. A pulse on ev_fault sets the mode-fault flag at bit 4. Both are visible from the next cycle.
- R4: The byte-complete and write-collision flags clear on a data_acc strobe that comes in a later cycle than a stat_rd strobe during which the flag was set. A data_acc strobe leaves the mode-fault flag unchanged.
- R5: The mode-fault flag clears on a ctrl_wr strobe that comes in a later cycle than a stat_rd strobe during which it was set. A ctrl_wr strobe leaves the other two flags unchanged.
- R6: A clearing strobe has no effect on a flag that has not been armed by a status read seen while the flag was set. A status read while the flag is clear does not arm it.
- R7: A set event for a flag takes priority over a clearing strobe in the same cycle and withdraws any arming. The flag then needs a new status read before it can be cleared.
- R8: Bits 5 and 3 to 0 of stat_rdata always read zero, even with every flag set.
- R9: When ev_done arrives while the byte-complete flag is already set, ovr_o is high for exactly the next cycle. In every other case ovr_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_done | input | 1 | Byte transfer completed (pulse) |
| ev_coll | input | 1 | Write collision detected by the engine (pulse) |
| ev_fault | input | 1 | Mode fault detected (pulse) |
| stat_rd | input | 1 | Status register read strobe |
| data_acc | input | 1 | Data register read or write strobe |
| ctrl_wr | input | 1 | Control register write strobe |
| stat_rdata | output | 8 | Status register read value |
| ovr_o | output | 1 | Receive overrun pulse |

## Verification
Two functions can meet in one cycle: a set event and a clearing strobe on an armed flag. A second case is a status read and a data access together. The bench drives both combinations in the same clock, once for byte complete and once for mode fault. It then judges the result by the cycles that follow. The flag must survive. A clearing strobe on its own must still fail to clear it. Only a fresh status read followed by the clearing access may clear it. An overrun is provoked in the same way: a byte completes in the cycle after the flag was armed, and the bench checks the overrun pulse together with the surviving flag.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int REG_W    = 8;
  localparam int NFLAG    = 3;
  // flag index order inside the block
  localparam int F_DONE   = 0;
  localparam int F_COLL   = 1;
  localparam int F_FAULT  = 2;
  // bit positions in the status view
  localparam int POS_DONE  = 7;
  localparam int POS_COLL  = 6;
  localparam int POS_FAULT = 4;
  // clearing source per flag: 1 = control write, 0 = data access
  localparam logic [NFLAG-1:0] CLR_BY_CTRL = 3'b100;

  function automatic int flag_pos(input int idx);
    case (idx)
      F_DONE:  return POS_DONE;
      F_COLL:  return POS_COLL;
      default: return POS_FAULT;
    endcase
  endfunction
endpackage

// File: rtl/spi_flag_cell.sv
module spi_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic look_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (set_i) begin
      flag_q <= 1'b1;
      arm_q  <= 1'b0;
    end else if (arm_q && clr_i) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (look_i && flag_q) begin
      arm_q  <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  // R6: a flag that is not armed cannot fall
  a_r6_clear_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !arm_q) |=> flag_q);
  // R7: a set event always leaves the flag set
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (flag_q && !arm_q));
  // R6: arming only exists on a set flag
  a_r6_arm_on_set: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |-> flag_q);
  // R4 / R5: armed flag with its clearing strobe falls
  a_r4_armed_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/spi_ovr_det.sv
module spi_ovr_det (
  input  logic clk,
  input  logic rst_n,
  input  logic done_ev_i,
  input  logic done_flag_i,
  output logic ovr_o
);
  logic ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= done_ev_i && done_flag_i;
  end

  assign ovr_o = ovr_q;

  // R9: the pulse lasts a single cycle unless a new event refreshes it
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !done_ev_i) |=> !ovr_q);
endmodule

// File: rtl/spi_stat_map.sv
module spi_stat_map
  import spi_stat_pkg::*;
(
  input  logic [NFLAG-1:0] flags_i,
  output logic [REG_W-1:0] view_o
);
  always_comb begin
    view_o = '0;
    for (int i = 0; i < NFLAG; i++) begin
      view_o[flag_pos(i)] = flags_i[i];
    end
  end
endmodule

// File: rtl/spi_stat_flags.sv
module spi_stat_flags
  import spi_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_done,
  input  logic             ev_coll,
  input  logic             ev_fault,
  input  logic             stat_rd,
  input  logic             data_acc,
  input  logic             ctrl_wr,
  output logic [REG_W-1:0] stat_rdata,
  output logic             ovr_o
);
  localparam logic [REG_W-1:0] USED_MASK =
    (REG_W'(1) << POS_DONE) | (REG_W'(1) << POS_COLL) | (REG_W'(1) << POS_FAULT);

  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;
  logic [NFLAG-1:0] flag_v;

  assign set_v[F_DONE]  = ev_done;
  assign set_v[F_COLL]  = ev_coll;
  assign set_v[F_FAULT] = ev_fault;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    if (CLR_BY_CTRL[g]) begin : g_ctrl
      assign clr_v[g] = ctrl_wr;
    end else begin : g_data
      assign clr_v[g] = data_acc;
    end
    spi_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v[g]),
      .look_i(stat_rd),
      .clr_i (clr_v[g]),
      .flag_o(flag_v[g])
    );
  end

  spi_stat_map u_map (
    .flags_i(flag_v),
    .view_o (stat_rdata)
  );

  spi_ovr_det u_ovr (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_ev_i  (ev_done),
    .done_flag_i(flag_v[F_DONE]),
    .ovr_o      (ovr_o)
  );

  // R8: unused positions stay zero
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata & ~USED_MASK) == '0);
  // R9: an overrun leaves the byte-complete flag set
  a_r9_ovr_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |-> stat_rdata[POS_DONE]);
  // R2: a byte event is visible next cycle
  a_r2_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> stat_rdata[POS_DONE]);
endmodule

// File: tb/spi_stat_flags_tb_top.sv
module spi_stat_flags_tb_top;
  localparam int CLK_PER = 10;
  localparam int NV = 34;
  // [19:16] requirement, [15] done [14] coll [13] fault [12] stat_rd
  // [11] data_acc [10] ctrl_wr [9] expected ovr [7:0] expected status
  localparam logic [19:0] VEC [NV] = '{
    {4'd2, 6'b100000, 2'b00, 8'h80},  // R2 set
    {4'd4, 6'b000100, 2'b00, 8'h80},  // R4 arm
    {4'd4, 6'b000010, 2'b00, 8'h00},  // R4 clear
    {4'd3, 6'b010000, 2'b00, 8'h40},  // R3 collision
    {4'd6, 6'b000010, 2'b00, 8'h40},  // R6 unarmed access
    {4'd4, 6'b000100, 2'b00, 8'h40},
    {4'd4, 6'b000010, 2'b00, 8'h00},
    {4'd3, 6'b001000, 2'b00, 8'h10},  // R3 fault
    {4'd5, 6'b000100, 2'b00, 8'h10},
    {4'd4, 6'b000010, 2'b00, 8'h10},  // R4 data access keeps fault
    {4'd5, 6'b000001, 2'b00, 8'h00},  // R5 clear fault
    {4'd3, 6'b110000, 2'b00, 8'hC0},
    {4'd5, 6'b000100, 2'b00, 8'hC0},
    {4'd5, 6'b000001, 2'b00, 8'hC0},  // R5 ctrl write keeps others
    {4'd4, 6'b000010, 2'b00, 8'h00},
    {4'd2, 6'b100000, 2'b00, 8'h80},
    {4'd9, 6'b100000, 2'b10, 8'h80},  // R9 overrun
    {4'd9, 6'b000000, 2'b00, 8'h80},
    {4'd7, 6'b000100, 2'b00, 8'h80},
    {4'd7, 6'b100000, 2'b10, 8'h80},  // R7 new event after arming
    {4'd7, 6'b000010, 2'b00, 8'h80},  // R7 arming withdrawn
    {4'd7, 6'b000100, 2'b00, 8'h80},
    {4'd7, 6'b000010, 2'b00, 8'h00},
    {4'd6, 6'b000100, 2'b00, 8'h00},  // R6 read while clear
    {4'd6, 6'b100000, 2'b00, 8'h80},
    {4'd6, 6'b000010, 2'b00, 8'h80},  // R6 not armed by earlier read
    {4'd6, 6'b000110, 2'b00, 8'h80},  // R6 read and access together
    {4'd4, 6'b000010, 2'b00, 8'h00},
    {4'd3, 6'b001000, 2'b00, 8'h10},
    {4'd7, 6'b000100, 2'b00, 8'h10},
    {4'd7, 6'b001001, 2'b00, 8'h10},  // R7 set and clear together
    {4'd7, 6'b000001, 2'b00, 8'h10},
    {4'd5, 6'b000100, 2'b00, 8'h10},
    {4'd5, 6'b000001, 2'b00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_done = 0, ev_coll = 0, ev_fault = 0;
  logic stat_rd = 0, data_acc = 0, ctrl_wr = 0;
  logic [7:0] stat_rdata;
  logic ovr_o;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PER/2) clk = ~clk;

  spi_stat_flags dut_i (
    .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_coll(ev_coll),
    .ev_fault(ev_fault), .stat_rd(stat_rd), .data_acc(data_acc),
    .ctrl_wr(ctrl_wr), .stat_rdata(stat_rdata), .ovr_o(ovr_o)
  );

  task automatic check(input string req, input logic [7:0] exp_rd, input logic exp_ovr);
    checks++;
    if (stat_rdata !== exp_rd || ovr_o !== exp_ovr) begin
      fails++;
      $display("FAIL %s: status=%02h ovr=%0b expected status=%02h ovr=%0b",
               req, stat_rdata, ovr_o, exp_rd, exp_ovr);
    end
  endtask

  task automatic drive(input logic [5:0] ev);
    @(negedge clk);
    {ev_done, ev_coll, ev_fault, stat_rd, data_acc, ctrl_wr} = ev;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", 8'h00, 1'b0);  // R1 reset state
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][15:10]);
      check($sformatf("R%0d vector %0d", VEC[i][19:16], i), VEC[i][7:0], VEC[i][9]);
    end
    // R8: every flag set, unused bits still zero
    drive(6'b111000);
    check("R8", 8'hD0, 1'b0);
    // R9: done event on a clear flag gives no overrun
    drive(6'b000100);
    drive(6'b000011);
    check("R9 pre", 8'h00, 1'b0);
    drive(6'b100000);
    check("R9 no overrun", 8'h80, 1'b0);
    // R1: reset while flags set and an event is pending
    drive(6'b111000);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check("R1 mid-run", 8'h00, 1'b0);
    drive(6'b000000);
    check("R1 held", 8'h00, 1'b0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule